// File: doc/BRIEF.md
# Flash Program and Erase Sequencer with Completion Polling

This block is a bus master for an asynchronous parallel NOR-style flash. It drives chip-enable, output-enable and write-enable with parameterised setup, strobe and hold counts. After a `start` pulse it runs one of two operations. The first is a word-program pass over an inclusive address range, with each word taken from a data source port. The second is a whole-chip erase. Once the command writes of an operation are issued, the block reads status words back from the flash until it can decide whether the operation finished.

Program completion is judged by one of two methods, selected per run. The first compares status bit 7 with bit 7 of the word written. The second looks for status bit 6 to stop flipping between two consecutive reads. Erase always uses the bit-6 method and then also demands an all-ones word. Status bit 5 is the flash's own time-out flag. When bit 5 is set, the block takes one more look before it declares failure, because the operation may have ended in the same read that raised the flag. A failure that holds after that look makes the block write a return-to-read command. The block then reports done, clears pass, and gives the address that failed. A poll-round limit catches a flash that never finishes.

Top module: `flash_pe_poller`

## Requirements
- R1: After reset, all three strobes are high, the data bus is not driven, and `busy` and `done` are low.
- R2: Every bus cycle presents the address for `T_SU` clocks with strobes high. It then holds chip-enable low together with exactly one of write-enable or output-enable for `T_PW` clocks, then keeps the address for `T_HD` clocks. The data bus is driven only in write cycles.
- R3: Program writes, for each word in ascending order from `first_addr` to `last_addr`: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then (word address, `src_data`). `src_addr` names the word.
- R4: Erase writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10.
- R5: With `poll_toggle`=0, a program word passes on the first status read at that address whose bit 7 equals bit 7 of the written word. While bit 7 differs and bit 5 is 0, reading repeats.
- R6: With `poll_toggle`=0, a read with bit 7 different and bit 5 set is followed by exactly one more read. The word passes if bit 7 now matches and fails otherwise.
- R7: With the bit-6 method, reads come in pairs. Equal bit 6 in a pair means complete. Different bit 6 with bit 5 of the second read clear starts a new pair.
- R8: Different bit 6 with bit 5 set triggers one more pair. That pair passes if bit 6 is equal and fails otherwise.
- R9: Erase uses the bit-6 method whatever `poll_toggle` is, reading at `first_addr`. It passes only if the read that ends the polling is 0xFFFF.
- R10: On failure the block writes 0x555/0x00F0. It then pulses `done` with `pass`=0 and `fail_addr` set to the word being polled, and programs no further words. On success, `fail_addr` is 0.
- R11: If `MAX_POLLS` poll rounds end without a verdict, the run fails as in R10.
- R12: `done` is high for exactly one clock. `pass` and `fail_addr` hold until the next start, and `start` while `busy` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_erase | input | 1 | 1 = chip erase, 0 = program range |
| poll_toggle | input | 1 | Program completion method: 1 = bit 6 pairs, 0 = bit 7 compare |
| first_addr | input | AW | First word address (erase: polling address) |
| last_addr | input | AW | Last word address, inclusive |
| src_addr | output | AW | Address of the word to be programmed |
| src_data | input | 16 | Word to program at `src_addr` |
| fl_ce_n | output | 1 | Flash chip enable, low active |
| fl_oe_n | output | 1 | Flash output enable, low active |
| fl_we_n | output | 1 | Flash write enable, low active |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 16 | Write data to flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 16 | Read data from flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| pass | output | 1 | Result of the last operation |
| fail_addr | output | AW | Word address of the failure, 0 on pass |

## Verification
Two events can occur in the same status read: the flash finishing and its time-out bit rising. A flash model in the bench can raise bit 5 on a chosen read and complete on a chosen later one. The race is provoked by setting bit 5 on the last status read, so that the confirming read or pair already shows the final data. The block must then report a pass without writing the return-to-read command. The same model with completion disabled must yield a failure, one abort write and the exact number of reads.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
package flash_pe_pkg;
    localparam int DQW = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEQ, ST_RA, ST_RB, ST_RC, ST_RD, ST_ABORT, ST_FIN
    } pe_state_e;

    typedef enum logic [1:0] {V_AGAIN, V_NEXT, V_PASS, V_FAIL} verdict_e;

    typedef enum logic [1:0] {PH_IDLE, PH_SU, PH_PW, PH_HD} bus_phase_e;

    localparam logic [11:0] UNLOCK_A = 12'h555;
    localparam logic [11:0] UNLOCK_B = 12'h2AA;
    localparam logic [15:0] ABORT_WORD = 16'h00F0;

    // {address[11:0], data[15:0]} for step idx of the unlock/command chain
    function automatic logic [27:0] seq_entry(input logic erase, input logic [2:0] idx);
        logic [27:0] e;
        unique case (idx)
            3'd0:    e = {UNLOCK_A, 16'h00AA};
            3'd1:    e = {UNLOCK_B, 16'h0055};
            3'd2:    e = {UNLOCK_A, erase ? 16'h0080 : 16'h00A0};
            3'd3:    e = {UNLOCK_A, 16'h00AA};
            3'd4:    e = {UNLOCK_B, 16'h0055};
            default: e = {UNLOCK_A, 16'h0010};
        endcase
        return e;
    endfunction
endpackage

// File: rtl/flash_bus_engine.sv
`timescale 1ns/1ps
module flash_bus_engine
    import flash_pe_pkg::*;
#(
    parameter int AW   = 19,
    parameter int T_SU = 1,
    parameter int T_PW = 2,
    parameter int T_HD = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           req_wr,
    input  logic [AW-1:0]  req_addr,
    input  logic [DQW-1:0] req_data,
    output logic           ack,
    output logic [DQW-1:0] rdata,
    output logic           ce_n,
    output logic           oe_n,
    output logic           we_n,
    output logic [AW-1:0]  addr,
    output logic [DQW-1:0] dq_out,
    output logic           dq_oe,
    input  logic [DQW-1:0] dq_in
);
    localparam int TMAX = (T_SU > T_PW) ? ((T_SU > T_HD) ? T_SU : T_HD)
                                        : ((T_PW > T_HD) ? T_PW : T_HD);
    localparam int CW = $clog2(TMAX + 1);
    localparam logic [CW-1:0] SU_END = CW'(T_SU - 1);
    localparam logic [CW-1:0] PW_END = CW'(T_PW - 1);
    localparam logic [CW-1:0] HD_END = CW'(T_HD - 1);

    typedef struct packed {
        bus_phase_e     ph;
        logic [CW-1:0]  cnt;
        logic           wr;
        logic [AW-1:0]  addr;
        logic [DQW-1:0] data;
        logic [DQW-1:0] rdata;
        logic           ce_n;
        logic           oe_n;
        logic           we_n;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: if (req) begin
                d.ph   = PH_SU;
                d.cnt  = '0;
                d.wr   = req_wr;
                d.addr = req_addr;
                d.data = req_data;
            end
            PH_SU: if (q.cnt == SU_END) begin
                d.ph   = PH_PW;
                d.cnt  = '0;
                d.ce_n = 1'b0;
                d.we_n = !q.wr;
                d.oe_n = q.wr;
            end else d.cnt = q.cnt + 1'b1;
            PH_PW: if (q.cnt == PW_END) begin
                d.ph   = PH_HD;
                d.cnt  = '0;
                d.ce_n = 1'b1;
                d.we_n = 1'b1;
                d.oe_n = 1'b1;
                if (!q.wr) d.rdata = dq_in;
            end else d.cnt = q.cnt + 1'b1;
            default: if (q.cnt == HD_END) begin
                d.ph = PH_IDLE;
                d.wr = 1'b0;
            end else d.cnt = q.cnt + 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.ce_n <= 1'b1;
            q.oe_n <= 1'b1;
            q.we_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ack    = (q.ph == PH_HD) && (q.cnt == HD_END);
    assign rdata  = q.rdata;
    assign ce_n   = q.ce_n;
    assign oe_n   = q.oe_n;
    assign we_n   = q.we_n;
    assign addr   = q.addr;
    assign dq_out = q.data;
    assign dq_oe  = q.wr && (q.ph != PH_IDLE);
endmodule

// File: rtl/flash_poll_judge.sv
`timescale 1ns/1ps
module flash_poll_judge
    import flash_pe_pkg::*;
(
    input  logic           use_toggle,
    input  logic           need_ones,
    input  logic [1:0]     stage,
    input  logic [DQW-1:0] rd,
    input  logic [DQW-1:0] prev,
    input  logic           want7,
    output verdict_e       verdict
);
    logic     stopped;
    verdict_e settled;

    always_comb begin
        stopped = (rd[6] == prev[6]);
        settled = (need_ones && (rd != '1)) ? V_FAIL : V_PASS;
        verdict = V_AGAIN;
        if (!use_toggle) begin
            if (stage == 2'd0)
                verdict = (rd[7] == want7) ? V_PASS : (rd[5] ? V_NEXT : V_AGAIN);
            else
                verdict = (rd[7] == want7) ? V_PASS : V_FAIL;
        end else begin
            unique case (stage)
                2'd0, 2'd2: verdict = V_NEXT;
                2'd1:       verdict = stopped ? settled : (rd[5] ? V_NEXT : V_AGAIN);
                default:    verdict = stopped ? settled : V_FAIL;
            endcase
        end
    end
endmodule

// File: rtl/flash_pe_poller.sv
`timescale 1ns/1ps
module flash_pe_poller
    import flash_pe_pkg::*;
#(
    parameter int AW        = 19,
    parameter int T_SU      = 1,
    parameter int T_PW      = 2,
    parameter int T_HD      = 1,
    parameter int MAX_POLLS = 4096
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           op_erase,
    input  logic           poll_toggle,
    input  logic [AW-1:0]  first_addr,
    input  logic [AW-1:0]  last_addr,
    output logic [AW-1:0]  src_addr,
    input  logic [15:0]    src_data,
    output logic           fl_ce_n,
    output logic           fl_oe_n,
    output logic           fl_we_n,
    output logic [AW-1:0]  fl_addr,
    output logic [15:0]    fl_dq_out,
    output logic           fl_dq_oe,
    input  logic [15:0]    fl_dq_in,
    output logic           busy,
    output logic           done,
    output logic           pass,
    output logic [AW-1:0]  fail_addr
);
    localparam int PCW = $clog2(MAX_POLLS + 1);
    localparam logic [PCW-1:0] POLL_END = PCW'(MAX_POLLS - 1);

    typedef struct packed {
        pe_state_e      st;
        logic [2:0]     idx;
        logic [AW-1:0]  cur;
        logic [DQW-1:0] wdata;
        logic [DQW-1:0] prev;
        logic           erase;
        logic           tog;
        logic           pass;
        logic [PCW-1:0] polls;
        logic [AW-1:0]  fail_addr;
    } ctl_t;

    ctl_t q, d;

    logic           req, req_wr, ack, data_step, polling;
    logic [AW-1:0]  req_addr;
    logic [DQW-1:0] req_data, rdata;
    logic [27:0]    seq;
    logic [1:0]     stage;
    verdict_e       verdict;

    flash_bus_engine #(.AW(AW), .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD)) bus_i (
        .clk(clk), .rst_n(rst_n),
        .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_data(req_data),
        .ack(ack), .rdata(rdata),
        .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n),
        .addr(fl_addr), .dq_out(fl_dq_out), .dq_oe(fl_dq_oe), .dq_in(fl_dq_in)
    );

    flash_poll_judge judge_i (
        .use_toggle(q.tog), .need_ones(q.erase), .stage(stage),
        .rd(rdata), .prev(q.prev), .want7(q.wdata[7]), .verdict(verdict)
    );

    always_comb begin
        seq       = seq_entry(q.erase, q.idx);
        data_step = !q.erase && (q.idx == 3'd3);
        polling   = (q.st == ST_RA) || (q.st == ST_RB) || (q.st == ST_RC) || (q.st == ST_RD);
        unique case (q.st)
            ST_RB:   stage = 2'd1;
            ST_RC:   stage = 2'd2;
            ST_RD:   stage = 2'd3;
            default: stage = 2'd0;
        endcase
        req      = (q.st == ST_SEQ) || (q.st == ST_ABORT) || polling;
        req_wr   = (q.st == ST_SEQ) || (q.st == ST_ABORT);
        req_addr = q.cur;
        req_data = '0;
        if (q.st == ST_ABORT) begin
            req_addr = AW'(UNLOCK_A);
            req_data = ABORT_WORD;
        end else if (q.st == ST_SEQ && !data_step) begin
            req_addr = AW'(seq[27:16]);
            req_data = seq[15:0];
        end else if (q.st == ST_SEQ) begin
            req_data = src_data;
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: if (start) begin
                d.st        = ST_SEQ;
                d.idx       = '0;
                d.cur       = first_addr;
                d.erase     = op_erase;
                d.tog       = op_erase || poll_toggle;
                d.pass      = 1'b0;
                d.fail_addr = '0;
            end
            ST_SEQ: if (ack) begin
                if (data_step) d.wdata = src_data;
                if (q.idx == (q.erase ? 3'd5 : 3'd3)) begin
                    d.st    = ST_RA;
                    d.polls = '0;
                end else d.idx = q.idx + 1'b1;
            end
            ST_RA, ST_RB, ST_RC, ST_RD: if (ack) begin
                d.prev = rdata;
                unique case (verdict)
                    V_NEXT: d.st = (q.st == ST_RA) ? ST_RB : ((q.st == ST_RB) ? ST_RC : ST_RD);
                    V_AGAIN: if (q.polls == POLL_END) begin
                        d.st        = ST_ABORT;
                        d.fail_addr = q.cur;
                    end else begin
                        d.polls = q.polls + 1'b1;
                        d.st    = ST_RA;
                    end
                    V_PASS: if (q.erase || q.cur == last_addr) begin
                        d.st   = ST_FIN;
                        d.pass = 1'b1;
                    end else begin
                        d.cur = q.cur + 1'b1;
                        d.idx = '0;
                        d.st  = ST_SEQ;
                    end
                    default: begin
                        d.st        = ST_ABORT;
                        d.fail_addr = q.cur;
                    end
                endcase
            end
            ST_ABORT: if (ack) d.st = ST_FIN;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign src_addr  = q.cur;
    assign busy      = (q.st != ST_IDLE);
    assign done      = (q.st == ST_FIN);
    assign pass      = q.pass;
    assign fail_addr = q.fail_addr;
endmodule

// File: rtl/flash_pe_poller_chk.sv
`timescale 1ns/1ps
module flash_pe_poller_chk #(
    parameter int AW   = 19,
    parameter int T_PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n,
    input logic [AW-1:0] fl_addr,
    input logic          fl_dq_oe,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic [AW-1:0] fail_addr
);
    logic [15:0] we_run, oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= fl_we_n ? 16'd0 : we_run + 16'd1;
            oe_run <= fl_oe_n ? 16'd0 : oe_run + 16'd1;
        end
    end

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    p_ce_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
    p_no_contention_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe);
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_ce_n |=> $stable(fl_addr));
    p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (we_run == 16'(T_PW)));
    p_oe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_oe_n) |-> (oe_run == 16'(T_PW)));
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_ce_n && !fl_dq_oe));
    p_pass_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fail_addr == '0));
endmodule

bind flash_pe_poller flash_pe_poller_chk #(.AW(AW), .T_PW(T_PW)) chk_i (
    .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_oe(fl_dq_oe),
    .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
);

// File: tb/flash_pe_poller_tb_top.sv
`timescale 1ns/1ps
module flash_pe_poller_tb_top;
    localparam int AW = 19, T_SU = 1, T_PW = 3, T_HD = 1, MAXP = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, op_erase = 1'b0, poll_toggle = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0, src_addr, fl_addr, fail_addr;
    logic [15:0] src_data, fl_dq_out, fl_dq_in;
    logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, busy, done, pass;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] pat(input logic [AW-1:0] a);
        return {8'hA5 ^ a[7:0], 3'b000, a[4:0]};
    endfunction
    assign src_data = pat(src_addr);

    flash_pe_poller #(.AW(AW), .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .poll_toggle(poll_toggle), .first_addr(first_addr), .last_addr(last_addr),
        .src_addr(src_addr), .src_data(src_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
    );

    // ---------------- flash model ----------------
    logic clr = 1'b1;
    int k_done_at = 0, k_t5_at = 0;
    logic k_bad = 1'b0;
    logic [7:0] k_bad_addr = '0;
    logic [15:0] mem [256];
    logic [11:0] log_a [64];
    logic [15:0] log_d [64];
    int log_n, n_f0, n_reads, nreads, step;
    logic [1:0] kind;
    logic tog, we_p, oe_p;
    logic [7:0] p_addr;
    logic [15:0] p_data, status;

    always_comb begin
        status = '0;
        status[7] = (kind == 2'd1) ? ~p_data[7] : 1'b0;
        status[6] = tog;
        status[5] = (k_t5_at != 0) && (nreads >= k_t5_at);
        status[2] = tog;
    end
    assign fl_dq_in = (kind != 2'd0) ? status : mem[fl_addr[7:0]];

    always @(posedge clk) begin
        we_p <= fl_we_n;
        oe_p <= fl_oe_n;
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'hFFFF;
            log_n <= 0; n_f0 <= 0; n_reads <= 0; nreads <= 0; step <= 0;
            kind <= 2'd0; tog <= 1'b0; p_addr <= '0; p_data <= '0;
        end else begin
            if (fl_we_n && !we_p) begin
                if (log_n < 64) begin
                    log_a[log_n] <= fl_addr[11:0];
                    log_d[log_n] <= fl_dq_out;
                    log_n <= log_n + 1;
                end
                if (fl_dq_out[7:0] == 8'hF0) begin
                    n_f0 <= n_f0 + 1; kind <= 2'd0; step <= 0;
                end else if (kind == 2'd0) begin
                    step <= 0;
                    case (step)
                        0: if (fl_addr[11:0] == 12'h555 && fl_dq_out[7:0] == 8'hAA) step <= 1;
                        1: if (fl_addr[11:0] == 12'h2AA && fl_dq_out[7:0] == 8'h55) step <= 2;
                        2: if (fl_addr[11:0] == 12'h555 && fl_dq_out[7:0] == 8'hA0) step <= 3;
                           else if (fl_addr[11:0] == 12'h555 && fl_dq_out[7:0] == 8'h80) step <= 4;
                        3: begin kind <= 2'd1; p_addr <= fl_addr[7:0]; p_data <= fl_dq_out;
                                 nreads <= 0; tog <= 1'b0; end
                        4: if (fl_addr[11:0] == 12'h555 && fl_dq_out[7:0] == 8'hAA) step <= 5;
                        5: if (fl_addr[11:0] == 12'h2AA && fl_dq_out[7:0] == 8'h55) step <= 6;
                        6: if (fl_addr[11:0] == 12'h555 && fl_dq_out[7:0] == 8'h10) begin
                               kind <= 2'd2; nreads <= 0; tog <= 1'b0; end
                        default: step <= 0;
                    endcase
                end
            end
            if (fl_oe_n && !oe_p) begin
                n_reads <= n_reads + 1;
                if (kind != 2'd0) begin
                    tog <= ~tog;
                    nreads <= nreads + 1;
                    if (k_done_at != 0 && nreads + 1 >= k_done_at) begin
                        kind <= 2'd0;
                        if (kind == 2'd1) mem[p_addr] <= p_data;
                        else begin
                            for (int i = 0; i < 256; i++) mem[i] <= 16'hFFFF;
                            if (k_bad) mem[k_bad_addr] <= 16'hFFFE;
                        end
                    end
                end
            end
        end
    end

    // ---------------- bus monitor (R2) ----------------
    int we_run = 0, oe_run = 0, su_run = 0, bus_viol = 0, n_strobes = 0, done_hi = 0;
    logic [AW-1:0] a_prev;
    always @(posedge clk) begin
        if (rst_n) begin
            a_prev <= fl_addr;
            if (!fl_we_n && !fl_oe_n) bus_viol <= bus_viol + 1;
            if ((!fl_we_n || !fl_oe_n) && fl_ce_n) bus_viol <= bus_viol + 1;
            if (!fl_we_n && !fl_dq_oe) bus_viol <= bus_viol + 1;
            if (!fl_oe_n && fl_dq_oe) bus_viol <= bus_viol + 1;
            if (!fl_ce_n && fl_addr != a_prev && we_run + oe_run > 0) bus_viol <= bus_viol + 1;
            we_run <= fl_we_n ? 0 : we_run + 1;
            oe_run <= fl_oe_n ? 0 : oe_run + 1;
            if (fl_we_n && we_run != 0) begin
                n_strobes <= n_strobes + 1;
                if (we_run != T_PW) bus_viol <= bus_viol + 1;
            end
            if (fl_oe_n && oe_run != 0 && oe_run != T_PW) bus_viol <= bus_viol + 1;
            if (done) done_hi <= done_hi + 1;
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0, n_bad = 0, cyc = 0;
    logic r_pass;
    logic [AW-1:0] r_fa;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_setup(input int dn, input int t5, input bit bad, input logic [7:0] bad_a);
        @(negedge clk);
        k_done_at = dn; k_t5_at = t5; k_bad = bad; k_bad_addr = bad_a;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        done_hi = 0;
    endtask

    task automatic run_op(input bit er, input bit tg, input logic [AW-1:0] fa,
                          input logic [AW-1:0] la, input bit poke);
        int t;
        @(negedge clk);
        op_erase = er; poll_toggle = tg; first_addr = fa; last_addr = la; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            if (poke && t == 10) begin start = 1'b1; op_erase = ~er; end
            if (poke && t == 11) begin start = 1'b0; op_erase = er; end
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        check(done == 1'b1, "R12 done reached", done, 1);
        r_pass = pass; r_fa = fail_addr;
        repeat (3) @(negedge clk);
    endtask

    function automatic bit log_is(input int i, input logic [11:0] a, input logic [15:0] dv);
        return log_a[i] == a && log_d[i] == dv;
    endfunction

    task automatic t_reset;
        check(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes high", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        check(!fl_dq_oe, "R1 bus released", fl_dq_oe, 0);
        check(!busy && !done, "R1 idle", {busy, done}, 0);
    endtask

    task automatic t_prog_data;
        bit ok;
        model_setup(3, 0, 0, 0);
        run_op(1'b0, 1'b0, 19'd4, 19'd6, 1'b1);
        check(r_pass, "R5 pass", r_pass, 1);
        check(r_fa == 0, "R10 fail_addr zero on pass", r_fa, 0);
        check(log_n == 12, "R12 start while busy ignored", log_n, 12);
        ok = 1;
        for (int w = 0; w < 3; w++)
            ok &= log_is(4*w, 12'h555, 16'h00AA) && log_is(4*w+1, 12'h2AA, 16'h0055) &&
                  log_is(4*w+2, 12'h555, 16'h00A0) && log_is(4*w+3, 12'(4+w), pat(19'(4+w)));
        check(ok, "R3 program write order", log_n, 12);
        check(mem[4] == pat(4) && mem[5] == pat(5) && mem[6] == pat(6), "R5 words stored", mem[5], pat(5));
        check(n_reads == 12, "R5 reads per word", n_reads, 12);
        check(done_hi == 1, "R12 done one clock", done_hi, 1);
        check(pass == r_pass, "R12 pass held", pass, r_pass);
    endtask

    task automatic t_race_data;
        model_setup(3, 2, 0, 0);
        run_op(1'b0, 1'b0, 19'd30, 19'd30, 1'b0);
        check(r_pass && n_f0 == 0, "R6 bit5 race passes", {r_pass, 8'(n_f0)}, 9'h100);
        check(n_reads == 4, "R6 one confirm read", n_reads, 4);
    endtask

    task automatic t_stuck_data;
        model_setup(0, 2, 0, 0);
        run_op(1'b0, 1'b0, 19'd20, 19'd22, 1'b0);
        check(!r_pass && r_fa == 20, "R6 confirmed failure", {r_pass, r_fa}, 20);
        check(n_reads == 4, "R6 confirm read count", n_reads, 4);
        check(n_f0 == 1 && log_n == 5 && log_is(4, 12'h555, 16'h00F0), "R10 abort write", log_d[4], 16'h00F0);
        check(mem[21] == 16'hFFFF, "R10 later words untouched", mem[21], 16'hFFFF);
    endtask

    task automatic t_prog_toggle;
        model_setup(4, 0, 0, 0);
        run_op(1'b0, 1'b1, 19'd10, 19'd11, 1'b0);
        check(r_pass && mem[10] == pat(10) && mem[11] == pat(11), "R7 toggle program", mem[11], pat(11));
        check(n_reads == 12, "R7 pair reads", n_reads, 12);
    endtask

    task automatic t_race_toggle;
        model_setup(2, 1, 0, 0);
        run_op(1'b0, 1'b1, 19'd40, 19'd40, 1'b0);
        check(r_pass && n_f0 == 0, "R8 bit5 race passes", r_pass, 1);
        check(n_reads == 4, "R8 extra pair", n_reads, 4);
    endtask

    task automatic t_stuck_toggle;
        model_setup(0, 1, 0, 0);
        run_op(1'b0, 1'b1, 19'd50, 19'd51, 1'b0);
        check(!r_pass && r_fa == 50 && n_f0 == 1, "R8 toggle failure aborts", r_fa, 50);
        check(n_reads == 4, "R8 failure read count", n_reads, 4);
    endtask

    task automatic t_erase;
        model_setup(4, 0, 0, 0);
        mem[7] = 16'h1234;
        run_op(1'b1, 1'b0, 19'd0, 19'd0, 1'b0);
        check(log_n == 6 && log_is(0, 12'h555, 16'h00AA) && log_is(1, 12'h2AA, 16'h0055) &&
              log_is(2, 12'h555, 16'h0080) && log_is(3, 12'h555, 16'h00AA) &&
              log_is(4, 12'h2AA, 16'h0055) && log_is(5, 12'h555, 16'h0010), "R4 erase writes", log_n, 6);
        check(r_pass && mem[7] == 16'hFFFF, "R9 erase passes", mem[7], 16'hFFFF);
        check(n_reads == 6, "R9 toggle method forced", n_reads, 6);
    endtask

    task automatic t_erase_bad;
        model_setup(4, 0, 1, 8'd3);
        run_op(1'b1, 1'b1, 19'd3, 19'd3, 1'b0);
        check(!r_pass && r_fa == 3 && n_f0 == 1, "R9 non-ones word fails", r_fa, 3);
    endtask

    task automatic t_watchdog;
        model_setup(0, 0, 0, 0);
        run_op(1'b0, 1'b1, 19'd60, 19'd60, 1'b0);
        check(!r_pass && r_fa == 60 && n_f0 == 1, "R11 watchdog failure", r_fa, 60);
        check(n_reads == 2*MAXP, "R11 poll rounds", n_reads, 2*MAXP);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_data();
        t_race_data();
        t_stuck_data();
        t_prog_toggle();
        t_race_toggle();
        t_stuck_toggle();
        t_erase();
        t_erase_bad();
        t_watchdog();
        check(bus_viol == 0 && n_strobes > 0, "R2 bus cycle timing", bus_viol, 0);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule